// File: doc/BRIEF.md
# Double-Buffered Time-Slot Routing Table

This block holds the slot routing for one time-division multiplexed channel. The receive direction and the transmit direction each own two physical banks of route entries. At any moment one bank in a direction drives the routing and the other bank is the shadow. Software may read every entry at any time. A write lands only when it targets the shadow bank of its direction, so the live route never changes in the middle of a frame.

To change a route, software fills the shadow bank and then pulses the swap request for that direction. The request stays pending until the next frame sync of that direction. On the clock edge that samples the sync, the two banks exchange roles, the pending bit clears, and the slot pointer restarts at entry 0. The two directions have separate syncs, requests and pointers, so they switch independently.

A per-direction sequencer walks the live bank. On each bit tick it counts off the length of the current entry. It then moves to the next entry, or back to entry 0 when the entry carries the last flag. The entry under the pointer drives a one-hot channel select and a strobe. The strobe can be wired to an interrupt input.

Top module: `tsa_route_table`

## Requirements
- R1: After reset, bank 0 is the live bank in both directions, both pending bits are 0, both pointers are 0 and every entry reads 0.
- R2: `tbl_rdata` shows, in the same cycle, the entry that `tbl_addr` selects. The address fields are: bit 8 picks the direction (0 receive, 1 transmit), bit 7 picks the physical bank, bits 6:2 give the entry index, and bits 1:0 are ignored.
- R3: A write (`tbl_we`=1) to the bank that is the shadow of its direction stores `tbl_wdata`. The new value reads back from the next cycle.
- R4: A write to the live bank of a direction is ignored. The entry keeps its old value.
- R5: A swap-request pulse sets the pending bit of its direction from the next cycle. When a sync arrives while the bit is pending, the live bank of that direction toggles and the pending bit clears, both visible one cycle after the sync.
- R6: A sync with no pending request leaves the live bank unchanged. A swap in one direction never changes the other direction's bank.
- R7: A sync sets the pointer and the bit count of its direction to 0, visible one cycle after the sync.
- R8: An entry has this layout: bits 1:0 channel code (0 none, 1 to 3 channels 0 to 2), bit 2 strobe, bits 6:3 slot length minus one, bit 7 last flag. With no sync, the pointer moves to the next entry on the bit tick that completes the slot length. It holds when no bit tick arrives.
- R9: When the slot of an entry with the last flag completes, the pointer returns to 0. The pointer also returns to 0 after the final index.
- R10: `*_chan` is one-hot, with bit c-1 set for channel code c and all bits zero for code 0. `*_strobe` equals the strobe flag. Both come from the live-bank entry under the pointer.
- R11: A swap-request pulse in the same cycle as a sync that performs a swap leaves the request pending for the following sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_addr | input | 9 | Table address (direction, bank, index, ignored bits) |
| tbl_we | input | 1 | Table write strobe |
| tbl_wdata | input | 8 | Table write data |
| tbl_rdata | output | 8 | Table read data for tbl_addr |
| rx_sync | input | 1 | Receive frame sync pulse |
| rx_bit_en | input | 1 | Receive bit tick |
| rx_swap_req | input | 1 | Receive bank swap request pulse |
| tx_sync | input | 1 | Transmit frame sync pulse |
| tx_bit_en | input | 1 | Transmit bit tick |
| tx_swap_req | input | 1 | Transmit bank swap request pulse |
| rx_bank | output | 1 | Receive live bank |
| tx_bank | output | 1 | Transmit live bank |
| rx_req_pend | output | 1 | Receive swap pending |
| tx_req_pend | output | 1 | Transmit swap pending |
| rx_ptr | output | 5 | Receive entry pointer |
| tx_ptr | output | 5 | Transmit entry pointer |
| rx_chan | output | 3 | Receive one-hot channel select |
| rx_strobe | output | 1 | Receive slot strobe |
| tx_chan | output | 3 | Transmit one-hot channel select |
| tx_strobe | output | 1 | Transmit slot strobe |

## Verification
Read data is combinational from the address, so it is compared in the same cycle. A write becomes visible on the read one edge later. Bank, pending bit and pointer each change one edge after the sync, request or tick that causes them, and channel and strobe follow the pointer at that same edge. Inputs are driven just after a rising edge. The reference model updates at that edge, and all outputs are compared on the falling edge, so each result is checked exactly one register stage after its cause.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
   localparam int CH_W    = 2;
   localparam int LEN_W   = 4;
   localparam int ENTRY_W = CH_W + 1 + LEN_W + 1;
   localparam int DIRS    = 2;

   typedef struct packed {
      logic             last;
      logic [LEN_W-1:0] len_m1;
      logic             strobe;
      logic [CH_W-1:0]  chan;
   } route_entry_t;
endpackage

// File: rtl/tsa_bank_store.sv
module tsa_bank_store
   import tsa_pkg::*;
#(
   parameter int ENTRIES = 32,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_bank,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [ENTRY_W-1:0] wr_data,
   input  logic               active_bank,
   input  logic               rd_bank,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [ENTRY_W-1:0] rd_data,
   input  logic [IDX_W-1:0]   act_idx,
   output logic [ENTRY_W-1:0] act_data
);
   logic [ENTRY_W-1:0] mem_q [2][ENTRIES];
   logic               wr_ok;

   // only the shadow bank of this direction accepts data
   assign wr_ok = wr_en && (wr_bank != active_bank);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < ENTRIES; i++) begin
               mem_q[b][i] <= '0;
            end
         end
      end else if (wr_ok) begin
         mem_q[wr_bank][wr_idx] <= wr_data;
      end
   end

   assign rd_data  = mem_q[rd_bank][rd_idx];
   assign act_data = mem_q[active_bank][act_idx];
endmodule

// File: rtl/tsa_slot_seq.sv
module tsa_slot_seq
   import tsa_pkg::*;
#(
   parameter int ENTRIES = 32,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync,
   input  logic             bit_en,
   input  logic             swap_req,
   input  logic [LEN_W-1:0] cur_len_m1,
   input  logic             cur_last,
   output logic             active_bank,
   output logic             req_pend,
   output logic [IDX_W-1:0] ptr
);
   logic             bank_q;
   logic             req_q;
   logic [IDX_W-1:0] ptr_q;
   logic [LEN_W-1:0] cnt_q;
   logic             slot_done;

   assign slot_done = bit_en && (cnt_q == cur_len_m1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_q <= 1'b0;
         req_q  <= 1'b0;
         ptr_q  <= '0;
         cnt_q  <= '0;
      end else if (sync) begin
         if (req_q) begin
            bank_q <= ~bank_q;
         end
         // a pending request is consumed; a new one in this cycle waits for the next sync
         req_q <= swap_req;
         ptr_q <= '0;
         cnt_q <= '0;
      end else begin
         if (swap_req) begin
            req_q <= 1'b1;
         end
         if (slot_done) begin
            cnt_q <= '0;
            ptr_q <= cur_last ? '0 : ptr_q + 1'b1;
         end else if (bit_en) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign active_bank = bank_q;
   assign req_pend    = req_q;
   assign ptr         = ptr_q;
endmodule

// File: rtl/tsa_route_decode.sv
module tsa_route_decode
   import tsa_pkg::*;
#(
   parameter int CHANNELS = 3
) (
   input  route_entry_t        entry,
   output logic [CHANNELS-1:0] chan_oh,
   output logic                strobe
);
   for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
      assign chan_oh[c] = (entry.chan == CH_W'(c + 1));
   end
   assign strobe = entry.strobe;
endmodule

// File: rtl/tsa_route_table.sv
module tsa_route_table
   import tsa_pkg::*;
#(
   parameter int ENTRIES  = 32,
   parameter int CHANNELS = 3,
   localparam int IDX_W   = $clog2(ENTRIES),
   localparam int ADDR_W  = IDX_W + 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   tbl_addr,
   input  logic                tbl_we,
   input  logic [ENTRY_W-1:0]  tbl_wdata,
   output logic [ENTRY_W-1:0]  tbl_rdata,
   input  logic                rx_sync,
   input  logic                rx_bit_en,
   input  logic                rx_swap_req,
   input  logic                tx_sync,
   input  logic                tx_bit_en,
   input  logic                tx_swap_req,
   output logic                rx_bank,
   output logic                tx_bank,
   output logic                rx_req_pend,
   output logic                tx_req_pend,
   output logic [IDX_W-1:0]    rx_ptr,
   output logic [IDX_W-1:0]    tx_ptr,
   output logic [CHANNELS-1:0] rx_chan,
   output logic                rx_strobe,
   output logic [CHANNELS-1:0] tx_chan,
   output logic                tx_strobe
);
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two");
   end
   if (CHANNELS < 1 || CHANNELS > (1 << CH_W) - 1) begin : g_bad_channels
      $error("CHANNELS does not fit the channel code");
   end

   logic [DIRS-1:0]     sync_v, bit_v, req_v, bank_v, pend_v, strobe_v;
   logic [IDX_W-1:0]    ptr_v  [DIRS];
   logic [CHANNELS-1:0] chan_v [DIRS];
   logic [ENTRY_W-1:0]  rd_v   [DIRS];

   logic             dir_sel;
   logic             bank_sel;
   logic [IDX_W-1:0] idx_sel;
   logic [1:0]       unused_lo;

   assign dir_sel   = tbl_addr[ADDR_W-1];
   assign bank_sel  = tbl_addr[ADDR_W-2];
   assign idx_sel   = tbl_addr[ADDR_W-3:2];
   assign unused_lo = tbl_addr[1:0];

   assign sync_v = {tx_sync, rx_sync};
   assign bit_v  = {tx_bit_en, rx_bit_en};
   assign req_v  = {tx_swap_req, rx_swap_req};

   for (genvar d = 0; d < DIRS; d++) begin : g_dir
      logic [ENTRY_W-1:0] act_raw;
      route_entry_t       act_entry;

      assign act_entry = route_entry_t'(act_raw);

      tsa_bank_store #(.ENTRIES(ENTRIES)) u_store (
         .clk         (clk),
         .rst_n       (rst_n),
         .wr_en       (tbl_we && (dir_sel == 1'(d))),
         .wr_bank     (bank_sel),
         .wr_idx      (idx_sel),
         .wr_data     (tbl_wdata),
         .active_bank (bank_v[d]),
         .rd_bank     (bank_sel),
         .rd_idx      (idx_sel),
         .rd_data     (rd_v[d]),
         .act_idx     (ptr_v[d]),
         .act_data    (act_raw)
      );

      tsa_slot_seq #(.ENTRIES(ENTRIES)) u_seq (
         .clk         (clk),
         .rst_n       (rst_n),
         .sync        (sync_v[d]),
         .bit_en      (bit_v[d]),
         .swap_req    (req_v[d]),
         .cur_len_m1  (act_entry.len_m1),
         .cur_last    (act_entry.last),
         .active_bank (bank_v[d]),
         .req_pend    (pend_v[d]),
         .ptr         (ptr_v[d])
      );

      tsa_route_decode #(.CHANNELS(CHANNELS)) u_dec (
         .entry   (act_entry),
         .chan_oh (chan_v[d]),
         .strobe  (strobe_v[d])
      );
   end

   assign tbl_rdata   = rd_v[dir_sel];
   assign rx_bank     = bank_v[0];
   assign tx_bank     = bank_v[1];
   assign rx_req_pend = pend_v[0];
   assign tx_req_pend = pend_v[1];
   assign rx_ptr      = ptr_v[0];
   assign tx_ptr      = ptr_v[1];
   assign rx_chan     = chan_v[0];
   assign tx_chan     = chan_v[1];
   assign rx_strobe   = strobe_v[0];
   assign tx_strobe   = strobe_v[1];
endmodule

// File: rtl/tsa_route_chk.sv
module tsa_route_chk #(
   parameter int IDX_W    = 5,
   parameter int CHANNELS = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sync,
   input logic                bit_en,
   input logic                swap_req,
   input logic                bank,
   input logic                req_pend,
   input logic [IDX_W-1:0]    ptr,
   input logic [CHANNELS-1:0] chan
);
   a_r5_swap_toggles: assert property (@(posedge clk) disable iff (!rst_n)
      (sync && req_pend) |=> (bank != $past(bank)));

   a_r5_req_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (sync && req_pend && !swap_req) |=> !req_pend);

   a_r5_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (req_pend && !sync) |=> req_pend);

   a_r6_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(sync && req_pend) |=> $stable(bank));

   a_r7_sync_ptr_zero: assert property (@(posedge clk) disable iff (!rst_n)
      sync |=> (ptr == '0));

   a_r8_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync && !bit_en) |=> $stable(ptr));

   a_r10_chan_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chan));

   a_r11_req_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (sync && swap_req) |=> req_pend);
endmodule

bind tsa_route_table tsa_route_chk #(.IDX_W(IDX_W), .CHANNELS(CHANNELS)) u_chk_rx (
   .clk      (clk),
   .rst_n    (rst_n),
   .sync     (rx_sync),
   .bit_en   (rx_bit_en),
   .swap_req (rx_swap_req),
   .bank     (rx_bank),
   .req_pend (rx_req_pend),
   .ptr      (rx_ptr),
   .chan     (rx_chan)
);

bind tsa_route_table tsa_route_chk #(.IDX_W(IDX_W), .CHANNELS(CHANNELS)) u_chk_tx (
   .clk      (clk),
   .rst_n    (rst_n),
   .sync     (tx_sync),
   .bit_en   (tx_bit_en),
   .swap_req (tx_swap_req),
   .bank     (tx_bank),
   .req_pend (tx_req_pend),
   .ptr      (tx_ptr),
   .chan     (tx_chan)
);

// File: tb/tsa_route_table_test.sv
module tsa_route_table_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] tbl_addr = '0;
   logic       tbl_we = 1'b0;
   logic [7:0] tbl_wdata = '0;
   logic [7:0] tbl_rdata;
   logic       rx_sync = 1'b0, rx_bit_en = 1'b0, rx_swap_req = 1'b0;
   logic       tx_sync = 1'b0, tx_bit_en = 1'b0, tx_swap_req = 1'b0;
   logic       rx_bank, tx_bank, rx_req_pend, tx_req_pend;
   logic [4:0] rx_ptr, tx_ptr;
   logic [2:0] rx_chan, tx_chan;
   logic       rx_strobe, tx_strobe;

   int  total = 0;
   int  bad = 0;
   bit  done = 1'b0;
   bit  run_cmp = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   tsa_route_table uut (
      .clk(clk), .rst_n(rst_n),
      .tbl_addr(tbl_addr), .tbl_we(tbl_we), .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata),
      .rx_sync(rx_sync), .rx_bit_en(rx_bit_en), .rx_swap_req(rx_swap_req),
      .tx_sync(tx_sync), .tx_bit_en(tx_bit_en), .tx_swap_req(tx_swap_req),
      .rx_bank(rx_bank), .tx_bank(tx_bank), .rx_req_pend(rx_req_pend), .tx_req_pend(tx_req_pend),
      .rx_ptr(rx_ptr), .tx_ptr(tx_ptr),
      .rx_chan(rx_chan), .rx_strobe(rx_strobe), .tx_chan(tx_chan), .tx_strobe(tx_strobe)
   );

   // behavioural reference model
   logic [7:0] m_mem [2][2][32];
   bit   m_bank [2];
   bit   m_req  [2];
   int   m_ptr  [2];
   int   m_cnt  [2];

   always @(posedge clk) begin
      bit sy [2];
      bit be [2];
      bit rq [2];
      logic [7:0] e [2];
      sy[0] = rx_sync; sy[1] = tx_sync;
      be[0] = rx_bit_en; be[1] = tx_bit_en;
      rq[0] = rx_swap_req; rq[1] = tx_swap_req;
      if (!rst_n) begin
         for (int d = 0; d < 2; d++) begin
            m_bank[d] = 0; m_req[d] = 0; m_ptr[d] = 0; m_cnt[d] = 0;
            for (int b = 0; b < 2; b++)
               for (int i = 0; i < 32; i++) m_mem[d][b][i] = 8'h00;
         end
      end else begin
         for (int d = 0; d < 2; d++) e[d] = m_mem[d][m_bank[d]][m_ptr[d]];
         if (tbl_we && (int'(tbl_addr[7]) != int'(m_bank[tbl_addr[8]])))
            m_mem[tbl_addr[8]][tbl_addr[7]][tbl_addr[6:2]] = tbl_wdata;
         for (int d = 0; d < 2; d++) begin
            if (sy[d]) begin
               if (m_req[d]) m_bank[d] = ~m_bank[d];
               m_req[d] = rq[d];
               m_ptr[d] = 0;
               m_cnt[d] = 0;
            end else begin
               if (rq[d]) m_req[d] = 1;
               if (be[d]) begin
                  if (m_cnt[d] == int'(e[d][6:3])) begin
                     m_cnt[d] = 0;
                     m_ptr[d] = e[d][7] ? 0 : (m_ptr[d] + 1) % 32;
                  end else begin
                     m_cnt[d] = m_cnt[d] + 1;
                  end
               end
            end
         end
      end
   end

   function automatic logic [2:0] exp_oh(input logic [7:0] ent);
      case (ent[1:0])
         2'd1:    return 3'b001;
         2'd2:    return 3'b010;
         2'd3:    return 3'b100;
         default: return 3'b000;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the rising edge
   always @(negedge clk) begin
      if (rst_n && run_cmp) begin
         logic [7:0] er, et, erd;
         er  = m_mem[0][m_bank[0]][m_ptr[0]];
         et  = m_mem[1][m_bank[1]][m_ptr[1]];
         erd = m_mem[tbl_addr[8]][tbl_addr[7]][tbl_addr[6:2]];
         chk(tbl_rdata == erd, "R2 rdata", tbl_rdata, erd);
         chk(rx_bank == m_bank[0] && tx_bank == m_bank[1], "R5 bank",
             {tx_bank, rx_bank}, {m_bank[1], m_bank[0]});
         chk(rx_req_pend == m_req[0] && tx_req_pend == m_req[1], "R5 pend",
             {tx_req_pend, rx_req_pend}, {m_req[1], m_req[0]});
         chk(int'(rx_ptr) == m_ptr[0], "R8 rx_ptr", rx_ptr, m_ptr[0]);
         chk(int'(tx_ptr) == m_ptr[1], "R8 tx_ptr", tx_ptr, m_ptr[1]);
         chk(rx_chan == exp_oh(er) && rx_strobe == er[2], "R10 rx out",
             {rx_strobe, rx_chan}, {er[2], exp_oh(er)});
         chk(tx_chan == exp_oh(et) && tx_strobe == et[2], "R10 tx out",
             {tx_strobe, tx_chan}, {et[2], exp_oh(et)});
      end
   end

   task automatic cycle();
      @(posedge clk);
      #2;
      tbl_we = 0; rx_sync = 0; tx_sync = 0; rx_bit_en = 0; tx_bit_en = 0;
      rx_swap_req = 0; tx_swap_req = 0;
   endtask

   task automatic wr(input logic [8:0] a, input logic [7:0] v);
      tbl_addr = a; tbl_wdata = v; tbl_we = 1;
      cycle();
   endtask

   task automatic rd_chk(input logic [8:0] a, input logic [7:0] v, input string tag);
      tbl_addr = a;
      #1;
      chk(tbl_rdata == v, tag, tbl_rdata, v);
   endtask

   task automatic rx_ticks(input int n);
      for (int i = 0; i < n; i++) begin rx_bit_en = 1; cycle(); end
   endtask

   task automatic tx_ticks(input int n);
      for (int i = 0; i < n; i++) begin tx_bit_en = 1; cycle(); end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      // R1 reset state
      chk(rx_bank == 0 && tx_bank == 0, "R1 banks", {tx_bank, rx_bank}, 0);
      chk(rx_req_pend == 0 && tx_req_pend == 0, "R1 pend", {tx_req_pend, rx_req_pend}, 0);
      chk(rx_ptr == 0 && tx_ptr == 0, "R1 ptr", {tx_ptr, rx_ptr}, 0);
      rd_chk(9'd388, 8'h00, "R1 entry zero");
      run_cmp = 1;

      // program receive shadow (bank 1) and one transmit shadow entry
      wr(9'd128, 8'h0D);   // ch0, strobe, 2 bits
      wr(9'd132, 8'h02);   // ch1, 1 bit
      wr(9'd136, 8'h93);   // ch2, 3 bits, last
      wr(9'd384, 8'h07);   // ch2, strobe, 1 bit
      rd_chk(9'd128, 8'h0D, "R3 shadow write");
      rd_chk(9'd139, 8'h93, "R2 low bits ignored");
      wr(9'd0, 8'hFF);
      rd_chk(9'd0, 8'h00, "R4 live write ignored");

      rx_sync = 1; cycle();
      chk(rx_bank == 0, "R6 sync without request", rx_bank, 0);

      rx_swap_req = 1; cycle();
      chk(rx_req_pend == 1 && rx_bank == 0, "R5 request pending", {rx_req_pend, rx_bank}, 2);
      rx_sync = 1; cycle();
      chk(rx_bank == 1 && rx_req_pend == 0, "R5 swap done", {rx_bank, rx_req_pend}, 2);
      chk(tx_bank == 0, "R6 tx unaffected", tx_bank, 0);
      chk(rx_chan == 3'b001 && rx_strobe == 1, "R10 first slot", {rx_strobe, rx_chan}, 4'h9);

      rx_ticks(1);
      chk(rx_ptr == 0, "R8 two-bit slot held", rx_ptr, 0);
      rx_ticks(1);
      chk(rx_ptr == 1 && rx_chan == 3'b010, "R8 advance", {rx_ptr, rx_chan}, {5'd1, 3'b010});
      rx_ticks(1);
      chk(rx_ptr == 2 && rx_chan == 3'b100, "R8 third entry", {rx_ptr, rx_chan}, {5'd2, 3'b100});
      rx_ticks(3);
      chk(rx_ptr == 0, "R9 last wraps", rx_ptr, 0);

      wr(9'd0, 8'h0A);
      rd_chk(9'd0, 8'h0A, "R3 old live bank now writable");
      wr(9'd128, 8'h00);
      rd_chk(9'd128, 8'h0D, "R4 new live bank protected");

      tx_swap_req = 1; cycle();
      tx_sync = 1; tx_swap_req = 1; cycle();
      chk(tx_bank == 1 && tx_req_pend == 1, "R11 request kept", {tx_bank, tx_req_pend}, 3);
      tx_sync = 1; cycle();
      chk(tx_bank == 0 && tx_req_pend == 0, "R11 second swap", {tx_bank, tx_req_pend}, 0);

      tx_ticks(5);
      chk(tx_ptr == 5, "R8 one-bit slots", tx_ptr, 5);
      tx_sync = 1; cycle();
      chk(tx_ptr == 0, "R7 sync resets pointer", tx_ptr, 0);
      tx_ticks(31);
      chk(tx_ptr == 31, "R9 final index", tx_ptr, 31);
      tx_ticks(1);
      chk(tx_ptr == 0, "R9 index wrap", tx_ptr, 0);

      // random traffic against the model
      for (int n = 0; n < 4000; n++) begin
         tbl_addr    = 9'($urandom);
         tbl_wdata   = 8'($urandom);
         tbl_we      = ($urandom_range(0, 3) == 0);
         rx_bit_en   = $urandom_range(0, 1) == 1;
         tx_bit_en   = $urandom_range(0, 1) == 1;
         rx_sync     = ($urandom_range(0, 39) == 0);
         tx_sync     = ($urandom_range(0, 39) == 0);
         rx_swap_req = ($urandom_range(0, 29) == 0);
         tx_swap_req = ($urandom_range(0, 29) == 0);
         cycle();
      end

      run_cmp = 0;
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule